// File: doc/BRIEF.md
# Multiplexed-Bus Register Interface Controller

This block is the register front end of a peripheral that hangs on an 8-bit microprocessor bus where address and data share the same lines. The host places a register address on the low bus bits and pulls the address strobe low. On that falling edge the block captures the 3-bit address and the chip-select level. Separate active-low read and write strobes then move a byte. The bus is driven only during a read that was selected at address time.

Behind the bus sit two control registers, a tone register and a read-only detect register. The detect register collects one-cycle pulses from the detect logic into sticky flags. While any flag is set, the block drives an open-drain interrupt pad low. The flags, and with them the interrupt, clear only when the host reads the detect register. A clock-select output requests the 16x data-rate clock in place of the crystal clock. That request takes effect only while the phase-shift-keying mode bit is set.

All bus strobes are brought into the system clock domain through two-flop synchronisers. Edges are detected on the synchronised levels. The bus output enable and the interrupt drive are registered so that neither can glitch.

Top module: `mbus_regif`

## Requirements
- R1: The falling edge of the address strobe `ale_i` captures `ad_i[2:0]` as the register address and captures `cs_ni` as the selection state. Later changes on those lines do not affect the transfer until the next falling edge.
- R2: `ad_oe_o` is high only while `rd_ni` is low and the captured selection is active (low). `ad_o` then holds the byte of the addressed register as it stood when the read strobe fell.
- R3: If the captured selection is inactive, `ad_oe_o` stays low for the whole read and a write changes no register.
- R4: `int_pd_o` (1 = pull the pad low) goes high within two cycles of any detect flag being set. It stays high until a read of the detect register clears the flags.
- R5: While `rst_ni` is low, both control registers, the tone register and the detect flags reset to zero, and `int_pd_o`, `ad_oe_o` and `clk_sel_o` reset to 0.
- R6: A one-cycle pulse on bit n of `det_i` sets detect flag n. The flag holds until the detect register is read, and that read returns the flag in bit n. A pulse that arrives in the same cycle as the clearing read is not lost and shows on the next read.
- R7: `clk_sel_o` is 1 (16x data-rate clock) only when bit 4 of control register 1 and bit 0 (phase-shift-keying mode) of control register 0 are both 1. Otherwise it is 0 (crystal clock).
- R8: Address map: 0 is control register 0, 1 is control register 1, 2 is the detect register and 3 is the tone register. A write to 2 is ignored. Addresses 4 to 7 read as 0x00 and ignore writes.
- R9: A write happens on the rising edge of `wr_ni` when the captured selection is active. The byte on `ad_i` at that edge is stored into the addressed register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ale_i | input | 1 | Address strobe; the falling edge captures the address and chip select |
| cs_ni | input | 1 | Chip select, active low, sampled with the address |
| rd_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Write strobe, active low; the rising edge commits the write |
| ad_i | input | 8 | Bus lines as seen at the pad input |
| ad_o | output | 8 | Read data towards the pad |
| ad_oe_o | output | 1 | Pad output enable for the bus |
| det_i | input | DET_W | One-cycle detect pulses |
| int_pd_o | output | 1 | Pull-down enable for the open-drain interrupt pad |
| clk_sel_o | output | 1 | 0 selects the crystal clock, 1 selects the 16x data-rate clock |

## Verification
The bench aims at four corner cases. The first is a detect pulse landing in the exact cycle that the detect read clears the flags: a design that clears after merging drops the pulse, so the next read shows zero and the interrupt falls. The second is a transfer addressed with chip select inactive: a design that decodes chip select live, or ignores it, drives the bus or overwrites control register 1. The third is writes to the read-only and unmapped addresses, which would corrupt the flags or read back non-zero. The fourth is the baud-clock request with the mode bit cleared, which must leave the crystal clock selected. The bench also confirms that reads of other registers leave the interrupt asserted, and that reset returns all state to zero.

// File: rtl/mbus_pkg.sv
package mbus_pkg;
  localparam int DW = 8;
  localparam int AW = 3;

  localparam logic [AW-1:0] REG_CTRL0 = 3'd0;
  localparam logic [AW-1:0] REG_CTRL1 = 3'd1;
  localparam logic [AW-1:0] REG_DET   = 3'd2;
  localparam logic [AW-1:0] REG_TONE  = 3'd3;

  localparam int CTRL0_PSK_BIT  = 0;
  localparam int CTRL1_BAUD_BIT = 4;
endpackage

// File: rtl/mbus_sync.sv
module mbus_sync #(
  parameter int W = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [1:0] ff_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ff_q <= {2{RST_VAL[i]}};
      else         ff_q <= {ff_q[0], d_i[i]};
    end
    assign q_o[i] = ff_q[1];
  end
endmodule

// File: rtl/mbus_regs.sv
module mbus_regs
  import mbus_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] ctrl0_o,
  output logic [DW-1:0] ctrl1_o,
  output logic [DW-1:0] tone_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl0_o <= '0;
      ctrl1_o <= '0;
      tone_o  <= '0;
    end else if (we_i) begin
      unique case (addr_i)
        REG_CTRL0: ctrl0_o <= wdata_i;
        REG_CTRL1: ctrl1_o <= wdata_i;
        REG_TONE:  tone_o  <= wdata_i;
        default: ;  // detect and unmapped: write dropped
      endcase
    end
  end
endmodule

// File: rtl/mbus_detect.sv
module mbus_detect #(
  parameter int DET_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DET_W-1:0] det_i,
  input  logic             clr_i,
  output logic [DET_W-1:0] flags_o,
  output logic             int_pd_o
);
  logic [DET_W-1:0] flags_d;

  // clear first, then merge, so a coincident pulse survives
  always_comb flags_d = (clr_i ? '0 : flags_o) | det_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_o  <= '0;
      int_pd_o <= 1'b0;
    end else begin
      flags_o  <= flags_d;
      int_pd_o <= |flags_o;
    end
  end

  AST_IRQ_ON_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|flags_o) |=> int_pd_o);  // R4
  AST_IRQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(int_pd_o) |-> $past(clr_i, 2));  // R4
  AST_PULSE_STICKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (det_i != '0) |=> ((flags_o & $past(det_i)) == $past(det_i)));  // R6
endmodule

// File: rtl/mbus_regif.sv
module mbus_regif
  import mbus_pkg::*;
#(
  parameter int DET_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ale_i,
  input  logic             cs_ni,
  input  logic             rd_ni,
  input  logic             wr_ni,
  input  logic [DW-1:0]    ad_i,
  output logic [DW-1:0]    ad_o,
  output logic             ad_oe_o,
  input  logic [DET_W-1:0] det_i,
  output logic             int_pd_o,
  output logic             clk_sel_o
);
  localparam int NSYNC = 4;

  logic [NSYNC-1:0] strb_s;
  logic ale_s, cs_n_s, rd_n_s, wr_n_s;
  logic ale_d, rd_d, wr_d;
  logic ale_fall, rd_fall, wr_rise;
  logic [AW-1:0] addr_q;
  logic cs_act_q;
  logic [DW-1:0] ctrl0, ctrl1, tone, rd_mux, rdata_q;
  logic [DET_W-1:0] flags;
  logic det_clr, we, oe_q;

  mbus_sync #(.W(NSYNC), .RST_VAL(4'b1110)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({wr_ni, rd_ni, cs_ni, ale_i}),
    .q_o   (strb_s)
  );
  assign {wr_n_s, rd_n_s, cs_n_s, ale_s} = strb_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ale_d <= 1'b0;
      rd_d  <= 1'b1;
      wr_d  <= 1'b1;
    end else begin
      ale_d <= ale_s;
      rd_d  <= rd_n_s;
      wr_d  <= wr_n_s;
    end
  end

  assign ale_fall = ale_d & ~ale_s;
  assign rd_fall  = rd_d & ~rd_n_s;
  assign wr_rise  = ~wr_d & wr_n_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q   <= '0;
      cs_act_q <= 1'b0;
    end else if (ale_fall) begin
      addr_q   <= ad_i[AW-1:0];
      cs_act_q <= ~cs_n_s;
    end
  end

  assign we      = wr_rise & cs_act_q;
  assign det_clr = rd_fall & cs_act_q & (addr_q == REG_DET);

  mbus_regs u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (we),
    .addr_i (addr_q),
    .wdata_i(ad_i),
    .ctrl0_o(ctrl0),
    .ctrl1_o(ctrl1),
    .tone_o (tone)
  );

  mbus_detect #(.DET_W(DET_W)) u_det (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .det_i   (det_i),
    .clr_i   (det_clr),
    .flags_o (flags),
    .int_pd_o(int_pd_o)
  );

  always_comb begin
    unique case (addr_q)
      REG_CTRL0: rd_mux = ctrl0;
      REG_CTRL1: rd_mux = ctrl1;
      REG_DET:   rd_mux = {{(DW-DET_W){1'b0}}, flags};
      REG_TONE:  rd_mux = tone;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      oe_q    <= 1'b0;
    end else begin
      if (rd_fall && cs_act_q) rdata_q <= rd_mux;
      oe_q <= ~rd_n_s & cs_act_q;
    end
  end

  assign ad_o      = rdata_q;
  assign ad_oe_o   = oe_q;
  assign clk_sel_o = ctrl1[CTRL1_BAUD_BIT] & ctrl0[CTRL0_PSK_BIT];

  AST_OE_NEEDS_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ad_oe_o |-> $past(cs_act_q));  // R2
  AST_NO_WRITE_DESEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_rise && !cs_act_q) |=> $stable({ctrl0, ctrl1, tone}));  // R3
endmodule

// File: tb/mbus_regif_tb.sv
module mbus_regif_tb;
  localparam int DET_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ale = 1'b0, cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [7:0] ad_in = '0;
  logic [7:0] ad_out;
  logic ad_oe, int_pd, clk_sel;
  logic [DET_W-1:0] det = '0;

  int n_chk = 0, n_fail = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];
  logic mon_req = 1'b0;

  always #10 clk = ~clk;

  mbus_regif #(.DET_W(DET_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ale_i(ale), .cs_ni(cs_n), .rd_ni(rd_n),
    .wr_ni(wr_n), .ad_i(ad_in), .ad_o(ad_out), .ad_oe_o(ad_oe),
    .det_i(det), .int_pd_o(int_pd), .clk_sel_o(clk_sel)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: compares sampled bus data against queued expectations
  always @(negedge clk) begin
    if (mon_req) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check({t, " oe"}, {7'b0, ad_oe}, 8'h01);
      check(t, ad_out, e);
      mon_req = 1'b0;
    end
  end

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic latch(input logic [2:0] a, input logic sel);
    @(negedge clk);
    ale = 1'b1; ad_in = {5'b0, a}; cs_n = ~sel;
    waitn(4);
    ale = 1'b0;
    waitn(5);
    ad_in = 8'hEE; cs_n = sel;  // disturb lines after capture (R1)
  endtask

  task automatic bus_wr(input logic [7:0] d);
    @(negedge clk);
    ad_in = d; wr_n = 1'b0;
    waitn(4);
    wr_n = 1'b1;
    waitn(5);
    ad_in = 8'hEE;
  endtask

  task automatic bus_rd(input logic [7:0] e, input string tag);
    @(negedge clk);
    rd_n = 1'b0;
    waitn(5);
    exp_q.push_back(e); tag_q.push_back(tag);
    @(posedge clk);
    mon_req = 1'b1;
    @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    rd_n = 1'b1;
    waitn(5);
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    latch(a, 1'b1);
    bus_wr(d);
  endtask

  task automatic rd_reg(input logic [2:0] a, input logic [7:0] e, input string tag);
    latch(a, 1'b1);
    bus_rd(e, tag);
  endtask

  task automatic pulse(input logic [DET_W-1:0] p);
    @(negedge clk); det = p;
    @(negedge clk); det = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    waitn(3);
    check("R5 oe at reset", {7'b0, ad_oe}, 8'h00);
    check("R5 int at reset", {7'b0, int_pd}, 8'h00);
    check("R5 clk_sel at reset", {7'b0, clk_sel}, 8'h00);
    rst_n = 1'b1;
    waitn(3);

    // R9 R1 R2 R8: basic writes and readback
    wr_reg(3'd0, 8'hA5);
    wr_reg(3'd1, 8'h3C);
    wr_reg(3'd3, 8'h81);
    rd_reg(3'd0, 8'hA5, "R9 ctrl0");
    rd_reg(3'd1, 8'h3C, "R1 ctrl1");
    rd_reg(3'd3, 8'h81, "R2 tone");

    // R8: read-only and unmapped
    wr_reg(3'd2, 8'hFF);
    rd_reg(3'd2, 8'h00, "R8 detect write ignored");
    wr_reg(3'd5, 8'h77);
    rd_reg(3'd5, 8'h00, "R8 unmapped");
    rd_reg(3'd0, 8'hA5, "R8 ctrl0 untouched");

    // R3: deselected write and read
    latch(3'd1, 1'b0);
    bus_wr(8'h00);
    latch(3'd1, 1'b0);
    @(negedge clk); rd_n = 1'b0;
    waitn(6);
    check("R3 no drive when deselected", {7'b0, ad_oe}, 8'h00);
    rd_n = 1'b1; waitn(5);
    rd_reg(3'd1, 8'h3C, "R3 ctrl1 kept");

    // R7: clock select gating
    check("R7 baud clk with psk", {7'b0, clk_sel}, 8'h01);
    wr_reg(3'd0, 8'hA4);
    check("R7 crystal without psk", {7'b0, clk_sel}, 8'h00);
    wr_reg(3'd0, 8'hA5);
    wr_reg(3'd1, 8'h2C);
    check("R7 crystal without request", {7'b0, clk_sel}, 8'h00);

    // R4 R6: sticky flags and interrupt
    pulse(4'b0101);
    waitn(2);
    check("R4 int on flag", {7'b0, int_pd}, 8'h01);
    rd_reg(3'd0, 8'hA5, "R4 other read");
    check("R4 int held", {7'b0, int_pd}, 8'h01);
    rd_reg(3'd2, 8'h05, "R6 flags read");
    check("R4 int released", {7'b0, int_pd}, 8'h00);
    rd_reg(3'd2, 8'h00, "R6 flags cleared");
    pulse(4'b0010);
    waitn(3);
    pulse(4'b1000);
    waitn(3);
    rd_reg(3'd2, 8'h0A, "R6 accumulated");

    // R6: pulse coincident with clearing read
    pulse(4'b0001);
    latch(3'd2, 1'b1);
    @(negedge clk); rd_n = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk); det = 4'b0100;
    @(negedge clk); det = '0;
    waitn(2);
    check("R6 snapshot before pulse", ad_out, 8'h01);
    rd_n = 1'b1; waitn(5);
    check("R6 int kept by coincident pulse", {7'b0, int_pd}, 8'h01);
    rd_reg(3'd2, 8'h04, "R6 coincident pulse kept");

    // R5: reset clears registers
    wr_reg(3'd1, 8'h10);
    check("R7 baud clk again", {7'b0, clk_sel}, 8'h01);
    @(negedge clk); rst_n = 1'b0;
    waitn(2);
    check("R5 clk_sel cleared", {7'b0, clk_sel}, 8'h00);
    rst_n = 1'b1;
    waitn(3);
    rd_reg(3'd0, 8'h00, "R5 ctrl0");
    rd_reg(3'd1, 8'h00, "R5 ctrl1");
    rd_reg(3'd3, 8'h00, "R5 tone");

    waitn(3);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule